// File: doc/BRIEF.md
# Immediate Command Handshake Controller

This block gives software a direct path for sending one command word to an external codec link and picking up the answer, without setting up a ring of command and response buffers. Software writes a 32-bit command word into a command register. It then starts the transfer by writing 1 to a busy bit in a 16-bit status register. The block presents the word on a valid/ready command interface. After the link accepts the word, the block waits for the matching response strobe. On that strobe it captures the response word, clears the busy bit itself, and raises a result-valid flag. Software clears that flag by writing 1 to it.

A small state machine runs the handshake. Its states are:
- `HS_IDLE`: no command is outstanding and busy reads 0.
- `HS_SEND`: the command is offered on the link.
- `HS_WAIT`: the command was accepted and the block waits for the response.

Its transitions are:
- start: `HS_IDLE` to `HS_SEND`, on a write of 1 to the busy bit.
- accept: `HS_SEND` to `HS_WAIT`, when `cmd_ready` is high at a clock edge.
- respond: `HS_WAIT` to `HS_IDLE`, when `rsp_valid` is high at a clock edge.

Every other input keeps the current state.

Register reads are combinational from the address. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `imm_cmd_ctrl`

## Requirements
- R1: After reset, the command register, the response register and the status register all read 0, and `cmd_valid` is low.
- R2: The register offsets are 60h for the command register, 64h for the response register and 68h for the status register. In the status register, bit 0 is busy and bit 1 is result-valid. Bits 31:2 of a status read, and any read of an unmapped offset, return 0.
- R3: A write to 68h with bit 0 set, made while busy is 0, sets busy to 1 in the next cycle. In that same cycle `cmd_valid` rises with `cmd_data` equal to the command register. Both stay unchanged until `cmd_ready` is sampled high, and `cmd_valid` is low in the cycle after that.
- R4: A `rsp_valid` strobe sampled after the command was accepted does three things in the next cycle: it loads `rsp_data` into the response register, clears busy, and sets result-valid.
- R5: Result-valid is write-1-to-clear: writing 1 to bit 1 of 68h clears it, and writing 0 leaves it unchanged. It is set only by a captured response.
- R6: While busy is 1, writing 1 to bit 0 starts no second command, and writing 0 to bit 0 does not cancel the command in progress.
- R7: Writes to 60h while busy is 1 are ignored, both in the register readback and on `cmd_data`.
- R8: A `rsp_valid` strobe that arrives when no accepted command is outstanding (in `HS_IDLE` or `HS_SEND`) is discarded. The response register and result-valid keep their values.
- R9: If a response is captured in the same cycle that software writes 1 to clear result-valid, result-valid ends up set.
- R10: While busy is 0, a write to 60h replaces the command register, and the new value reads back.
- R11: The response register is read-only: writes to 64h leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cmd_valid | output | 1 | Command word offered on the link |
| cmd_data | output | 32 | Command word |
| cmd_ready | input | 1 | Link accepts the command word |
| rsp_valid | input | 1 | Response word present on the link |
| rsp_data | input | 32 | Response word |

## Verification
A state machine stuck in or skipping a state shows within one cycle. The symptoms are a busy bit that disagrees with `cmd_valid`, a command offered twice, or a response captured before acceptance. Each of these is visible at the next status read or on the link outputs. A wrong flag priority or a missing write guard only shows in the register readback taken right after the colliding cycle. For that reason the bench creates each collision on purpose: a clear coinciding with a capture, a command write while busy, and strobes in idle and in the send phase. It then reads the registers at once.

// File: rtl/imm_cmd_pkg.sv
package imm_cmd_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_RSP  = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h68;

    localparam int BIT_BUSY  = 0;
    localparam int BIT_VALID = 1;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_SEND = 2'd1,
        HS_WAIT = 2'd2
    } hs_state_e;
endpackage

// File: rtl/imm_reg_decode.sv
module imm_reg_decode
    import imm_cmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [1:0]    wdata_flags,
    input  logic [DW-1:0] cmd_q,
    input  logic [DW-1:0] rsp_q,
    input  logic          busy,
    input  logic          valid_flag,
    output logic          wr_cmd,
    output logic          start_req,
    output logic          clr_req,
    output logic [DW-1:0] reg_rdata
);
    logic wr_stat;

    always_comb begin
        wr_cmd    = reg_wr && (reg_addr == OFS_CMD);
        wr_stat   = reg_wr && (reg_addr == OFS_STAT);
        start_req = wr_stat && wdata_flags[BIT_BUSY];
        clr_req   = wr_stat && wdata_flags[BIT_VALID];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_RSP:  reg_rdata = rsp_q;
            OFS_STAT: begin
                reg_rdata[BIT_BUSY]  = busy;
                reg_rdata[BIT_VALID] = valid_flag;
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/imm_hs_fsm.sv
module imm_hs_fsm
    import imm_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic cmd_ready,
    input  logic rsp_valid,
    output logic cmd_valid,
    output logic busy,
    output logic rsp_take,
    output logic cmd_wr_ok
);
    hs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (start_req) state_d = HS_SEND;
            HS_SEND: if (cmd_ready) state_d = HS_WAIT;
            HS_WAIT: if (rsp_valid) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        busy      = 1'b1;
        rsp_take  = 1'b0;
        cmd_wr_ok = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                busy      = 1'b0;
                cmd_wr_ok = 1'b1;
            end
            HS_SEND: cmd_valid = 1'b1;
            HS_WAIT: rsp_take  = rsp_valid;
            default: busy      = 1'b0;
        endcase
    end
endmodule

// File: rtl/imm_data_regs.sv
module imm_data_regs
    import imm_cmd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic          cmd_wr_ok,
    input  logic [DW-1:0] wdata,
    input  logic          rsp_take,
    input  logic [DW-1:0] rsp_data,
    input  logic          clr_req,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] rsp_q,
    output logic          valid_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd && cmd_wr_ok) begin
            cmd_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (rsp_take) begin
            rsp_q <= rsp_data;
        end
    end

    // A capture takes priority over a software clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        valid_flag <= 1'b0;
        else if (rsp_take) valid_flag <= 1'b1;
        else if (clr_req)  valid_flag <= 1'b0;
    end
endmodule

// File: rtl/imm_cmd_ctrl.sv
module imm_cmd_ctrl
    import imm_cmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_data,
    input  logic          cmd_ready,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data
);
    logic          wr_cmd, start_req, clr_req;
    logic          busy, rsp_take, cmd_wr_ok, valid_flag;
    logic [DW-1:0] cmd_q, rsp_q;

    imm_reg_decode #(.DW(DW), .AW(AW)) u_dec (
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .wdata_flags (reg_wdata[1:0]),
        .cmd_q       (cmd_q),
        .rsp_q       (rsp_q),
        .busy        (busy),
        .valid_flag  (valid_flag),
        .wr_cmd      (wr_cmd),
        .start_req   (start_req),
        .clr_req     (clr_req),
        .reg_rdata   (reg_rdata)
    );

    imm_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .cmd_valid (cmd_valid),
        .busy      (busy),
        .rsp_take  (rsp_take),
        .cmd_wr_ok (cmd_wr_ok)
    );

    imm_data_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .cmd_wr_ok  (cmd_wr_ok),
        .wdata      (reg_wdata),
        .rsp_take   (rsp_take),
        .rsp_data   (rsp_data),
        .clr_req    (clr_req),
        .cmd_q      (cmd_q),
        .rsp_q      (rsp_q),
        .valid_flag (valid_flag)
    );

    assign cmd_data = cmd_q;
endmodule

// File: rtl/imm_cmd_ctrl_chk.sv
module imm_cmd_ctrl_chk
    import imm_cmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          cmd_valid,
    input logic [DW-1:0] cmd_data,
    input logic          cmd_ready,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          busy,
    input logic          valid_flag,
    input logic [DW-1:0] rsp_q
);
    logic waiting;
    assign waiting = busy && !cmd_valid;

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT) |-> (reg_rdata[DW-1:2] == '0));

    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    p_valid_means_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid) |=> (!busy && valid_flag && rsp_q == $past(rsp_data)));

    p_set_only_by_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_flag) |-> $past(waiting && rsp_valid));

    p_no_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(waiting && rsp_valid)) |=> busy);

    p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == OFS_CMD) |=> $stable(cmd_data));

    p_stray_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !waiting) |=> $stable(rsp_q));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid && reg_wr && reg_addr == OFS_STAT && reg_wdata[BIT_VALID])
        |=> valid_flag);
endmodule

bind imm_cmd_ctrl imm_cmd_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .busy       (busy),
    .valid_flag (valid_flag),
    .rsp_q      (rsp_q)
);

// File: tb/tb_imm_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_imm_cmd_ctrl;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_CMD  = 8'h60;
    localparam logic [AW-1:0] A_RSP  = 8'h64;
    localparam logic [AW-1:0] A_STAT = 8'h68;
    localparam int NVEC = 4;
    // {command word, response word, ready delay in cycles}
    localparam logic [71:0] VEC [NVEC] = '{
        {32'hA5A5_0001, 32'h1234_5678, 8'd0},
        {32'hFFFF_FFFF, 32'h0000_0000, 8'd2},
        {32'h0000_0000, 32'hFFFF_FFFF, 8'd1},
        {32'h8000_0001, 32'hDEAD_BEEF, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cmd_valid;
    logic [DW-1:0] cmd_data;
    logic          cmd_ready = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    imm_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_ready();
        @(negedge clk); cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
    endtask

    task automatic pulse_rsp(input logic [DW-1:0] d);
        @(negedge clk); rsp_valid = 1'b1; rsp_data = d;
        @(negedge clk); rsp_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CMD, v);  check("R1 cmd reset", v, 0);
        rd(A_RSP, v);  check("R1 rsp reset", v, 0);
        rd(A_STAT, v); check("R1 status reset", v, 0);
        check("R1 cmd_valid reset", {31'b0, cmd_valid}, 0);
        // R2 unmapped offset
        rd(8'h6C, v); check("R2 unmapped read", v, 0);

        // vector table: full handshakes
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] c, r;
            logic [7:0]  dly;
            {c, r, dly} = VEC[i];
            wr(A_CMD, c);
            rd(A_CMD, v); check("R10 cmd readback", v, c);
            wr(A_STAT, 32'h2);
            wr(A_STAT, 32'h1);
            check("R3 cmd_valid rises", {31'b0, cmd_valid}, 1);
            check("R3 cmd_data", cmd_data, c);
            rd(A_STAT, v); check("R2 busy bit", v, 32'h1);
            for (int k = 0; k < int'(dly); k++) begin
                @(negedge clk);
                check("R3 held while not ready", {31'b0, cmd_valid}, 1);
            end
            pulse_ready();
            check("R3 cmd_valid drops", {31'b0, cmd_valid}, 0);
            rd(A_STAT, v); check("R3 busy while waiting", v, 32'h1);
            pulse_rsp(r);
            rd(A_STAT, v); check("R4 status after response", v, 32'h2);
            rd(A_RSP, v);  check("R4 response captured", v, r);
        end

        // R5: writing 0 leaves valid, writing 1 clears
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R5 write 0 keeps valid", v, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); check("R5 write 1 clears", v, 32'h0);

        // R11: response register read-only
        wr(A_RSP, 32'h5555_AAAA);
        rd(A_RSP, v); check("R11 rsp read-only", v, 32'hDEAD_BEEF);

        // R8: stray response in idle
        pulse_rsp(32'h0BAD_0BAD);
        rd(A_RSP, v);  check("R8 idle stray rsp", v, 32'hDEAD_BEEF);
        rd(A_STAT, v); check("R8 idle stray valid", v, 32'h0);

        // start a command, then collide with it
        wr(A_CMD, 32'h1111_2222);
        wr(A_STAT, 32'h1);
        // R8: response during send phase
        pulse_rsp(32'h0BAD_0001);
        rd(A_RSP, v);  check("R8 send-phase rsp", v, 32'hDEAD_BEEF);
        rd(A_STAT, v); check("R8 send-phase status", v, 32'h1);
        // R7: command write while busy
        wr(A_CMD, 32'h3333_4444);
        rd(A_CMD, v); check("R7 cmd reg frozen", v, 32'h1111_2222);
        check("R7 cmd_data frozen", cmd_data, 32'h1111_2222);
        // R6: write 0 does not cancel; write 1 does not restart
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R6 write 0 no cancel", v, 32'h1);
        check("R6 still offered", {31'b0, cmd_valid}, 1);
        pulse_ready();
        wr(A_STAT, 32'h1);
        check("R6 no second offer", {31'b0, cmd_valid}, 0);
        rd(A_STAT, v); check("R6 still waiting", v, 32'h1);

        // R9: capture and clear in the same cycle
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 32'h7777_8888;
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h2;
        @(negedge clk);
        rsp_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(A_STAT, v); check("R9 set wins", v, 32'h2);
        rd(A_RSP, v);  check("R9 response stored", v, 32'h7777_8888);
        @(negedge clk);
        check("R6 no restart after done", {31'b0, cmd_valid}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule